// File: doc/BRIEF.md
# Dual Interval Timer with Reload Latch

This block holds two 16-bit down-counters that advance on a shared tick. An internal prescaler divides the input clock by a parameter, six by default. Software reaches the timers through single-byte writes and reads addressed by a 4-bit register index. A decoder outside the block turns bus cycles into those index and strobe signals. An interrupt combiner, also outside, consumes the one-cycle flag-set and flag-clear pulses that the block raises.

Timer one keeps a 16-bit reload latch. It counts from the loaded value down to zero, then spends one extra tick at all-ones, then reloads from the latch, so a latch value L gives a period of L+2 ticks. A two-state machine tracks this. `T1_DOWN` is ordinary counting; its transition *hit-zero* goes to `T1_UNDER` with the count at all-ones. `T1_UNDER` takes the transition *reload* back to `T1_DOWN` with the latch value. A counter-loading write forces *load* to `T1_DOWN` from either state. When the mode field equals `01`, the block pulses the timer one flag on every tick that leaves the count at zero.

Timer two is a one-shot counter. Its machine starts in `T2_IDLE`. A high-byte write takes the transition *arm* to `T2_ARMED` and loads the count. The first wrap from zero to all-ones pulses the timer two flag and takes the transition *fire* back to `T2_IDLE`. The counter keeps decrementing and wrapping, and it raises no further flag until it is loaded again.

Top module: `dual_itimer`

## Requirements
- R1: After reset, timer one's latch and count both read 0xFFFF, timer two's count reads 0xFFFF, and timer two's low latch is 0x00.
- R2: `tick_out` is high for exactly one clock out of every PRESCALE_DIV clocks (6 by default), and both counters move only on clocks where it is high.
- R3: A write to index 5 puts the data byte into latch bits [15:8], loads the counter with the complete new latch, and pulses `t1_flag_clr` for one cycle.
- R4: A write to index 7 puts the data byte into latch bits [15:8] and pulses `t1_flag_clr`, but leaves the timer one count unchanged.
- R5: A write to index 4 or to index 6 changes only latch bits [7:0]. It neither changes the count nor pulses `t1_flag_clr`.
- R6: On each tick, timer one decrements. From zero it goes to 0xFFFF, and on the next tick it reloads the latch, so the period is latch+2 ticks.
- R7: When `acr_mode` equals 2'b01, `t1_flag_set` pulses for one cycle in the same cycle the count becomes zero on a tick, including a reload of a zero latch. With any other `acr_mode` value it stays low.
- R8: A write to index 8 stores timer two's low latch and leaves its count alone. A write to index 9 loads timer two's count with {data, low latch}.
- R9: Timer two decrements on every tick and wraps from 0x0000 to 0xFFFF. `t2_flag_set` pulses only on the first wrap after an index-9 load.
- R10: `rd_data` returns, for `rd_idx` 4/5, timer one count bits [7:0]/[15:8]; for 6/7, timer one latch bits [7:0]/[15:8]; for 8/9, timer two count bits [7:0]/[15:8]; for any other index, zero.
- R11: When an index-5 write lands on a tick clock, the load takes priority. The count equals the new latch with no decrement applied, and no flag-set pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 8 | Write data byte |
| acr_mode | input | 2 | Timer one mode field; 2'b01 selects free-running with flags |
| rd_idx | input | 4 | Register index for readback |
| rd_data | output | 8 | Readback byte for `rd_idx` |
| tick_out | output | 1 | Prescaled tick enable |
| t1_count | output | 16 | Live timer one count |
| t1_latch | output | 16 | Timer one reload latch |
| t2_count | output | 16 | Live timer two count |
| t1_flag_set | output | 1 | Timer one flag-set pulse |
| t1_flag_clr | output | 1 | Timer one flag-clear pulse |
| t2_flag_set | output | 1 | Timer two flag-set pulse |

## Verification
The decrement-or-reload step and a counter-loading write to index 5 can both fall on the same clock edge. The bench provokes this by counting clocks from an observed tick and then timing the write so that it lands exactly on the next tick. The result is judged correct when the count shows the newly written latch with no decrement, the flag-clear pulse fires, no flag-set pulse appears, and the following tick leaves the count at latch minus one.

// File: rtl/itl_pkg.sv
package itl_pkg;

    // Register indices; an external decoder drives these codes.
    localparam logic [3:0] IDX_T1_CNT_LO = 4'd4;
    localparam logic [3:0] IDX_T1_CNT_HI = 4'd5;
    localparam logic [3:0] IDX_T1_LAT_LO = 4'd6;
    localparam logic [3:0] IDX_T1_LAT_HI = 4'd7;
    localparam logic [3:0] IDX_T2_LO     = 4'd8;
    localparam logic [3:0] IDX_T2_HI     = 4'd9;

    // Mode field value that enables periodic flags on timer one.
    localparam logic [1:0] MODE_FREE_RUN = 2'b01;

    typedef enum logic {
        T1_DOWN  = 1'b0,
        T1_UNDER = 1'b1
    } t1_phase_e;

    typedef enum logic {
        T2_IDLE  = 1'b0,
        T2_ARMED = 1'b1
    } t2_phase_e;

endpackage

// File: rtl/itl_prescale.sv
module itl_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    assign tick_o = (div_q == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            // R2: a tick never lasts two consecutive clocks
            p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("tick lasted more than one clock");
        end
    endgenerate

endmodule

// File: rtl/itl_timer1.sv
module itl_timer1
    import itl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             free_run_i,
    input  logic             lat_lo_wr_i,
    input  logic             lat_hi_wr_i,
    input  logic             load_wr_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] latch_o,
    output logic             flag_set_o,
    output logic             flag_clr_o
);
    localparam int BYTE_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    t1_phase_e        phase_q, phase_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] latch_q, latch_d;
    logic             set_q, set_d;
    logic             clr_q, clr_d;

    // Next-state process
    always_comb begin
        phase_d = phase_q;
        count_d = count_q;
        latch_d = latch_q;
        set_d   = 1'b0;
        clr_d   = lat_hi_wr_i | load_wr_i;

        if (lat_lo_wr_i) begin
            latch_d[BYTE_W-1:0] = wdata_i;
        end
        if (lat_hi_wr_i || load_wr_i) begin
            latch_d[CNT_W-1:BYTE_W] = wdata_i;
        end

        if (load_wr_i) begin
            count_d = {wdata_i, latch_q[BYTE_W-1:0]};
            phase_d = T1_DOWN;
        end else if (tick_i) begin
            unique case (phase_q)
                T1_DOWN: begin
                    if (count_q == '0) begin
                        count_d = ALL_ONES;
                        phase_d = T1_UNDER;
                    end else begin
                        count_d = count_q - CNT_W'(1);
                    end
                end
                T1_UNDER: begin
                    count_d = latch_q;
                    phase_d = T1_DOWN;
                end
            endcase
            set_d = free_run_i && (count_d == '0);
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= T1_DOWN;
            count_q <= ALL_ONES;
            latch_q <= ALL_ONES;
            set_q   <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            count_q <= count_d;
            latch_q <= latch_d;
            set_q   <= set_d;
            clr_q   <= clr_d;
        end
    end

    // Output process
    always_comb begin
        count_o    = count_q;
        latch_o    = latch_q;
        flag_set_o = set_q;
        flag_clr_o = clr_q;
    end

    // R6: ordinary tick in the down phase removes exactly one
    p_t1_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_wr_i && phase_q == T1_DOWN && count_q != '0)
        |=> (count_q == $past(count_q) - CNT_W'(1)))
        else $error("timer one decrement wrong");

    // R6: the tick after the all-ones step restores the latch
    p_t1_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_wr_i && phase_q == T1_UNDER)
        |=> (count_q == $past(latch_q)))
        else $error("timer one reload wrong");

    // R3: a loading write leaves count equal to the new latch
    p_t1_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> (count_q == latch_q))
        else $error("timer one load mismatch");

    // R4: latch-high write alone does not move the count
    p_t1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_hi_wr_i && !tick_i) |=> $stable(count_q))
        else $error("latch-high write moved the count");

    // R7: a flag pulse only accompanies a zero count
    p_t1_flag_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_o |-> (count_q == '0))
        else $error("timer one flag without zero count");

endmodule

// File: rtl/itl_timer2.sv
module itl_timer2
    import itl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               lo_wr_i,
    input  logic               hi_wr_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    output logic [CNT_W-1:0]   count_o,
    output logic               flag_set_o
);
    localparam int BYTE_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    t2_phase_e         phase_q, phase_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [BYTE_W-1:0] low_q, low_d;
    logic              set_q, set_d;

    // Next-state process
    always_comb begin
        phase_d = phase_q;
        count_d = count_q;
        low_d   = lo_wr_i ? wdata_i : low_q;
        set_d   = 1'b0;

        if (hi_wr_i) begin
            count_d = {wdata_i, low_q};
            phase_d = T2_ARMED;
        end else if (tick_i) begin
            count_d = count_q - CNT_W'(1);
            unique case (phase_q)
                T2_IDLE: begin
                    phase_d = T2_IDLE;
                end
                T2_ARMED: begin
                    if (count_q == '0) begin
                        set_d   = 1'b1;
                        phase_d = T2_IDLE;
                    end
                end
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= T2_IDLE;
            count_q <= ALL_ONES;
            low_q   <= '0;
            set_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            count_q <= count_d;
            low_q   <= low_d;
            set_q   <= set_d;
        end
    end

    // Output process
    always_comb begin
        count_o    = count_q;
        flag_set_o = set_q;
    end

    // R8: high write sets the upper count byte
    p_t2_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_i |=> (count_q[CNT_W-1:BYTE_W] == $past(wdata_i)))
        else $error("timer two load mismatch");

    // R9: the one-shot flag disarms and coincides with the wrap
    p_t2_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_o |-> (phase_q == T2_IDLE && count_q == ALL_ONES))
        else $error("timer two flag outside first wrap");

endmodule

// File: rtl/dual_itimer.sv
module dual_itimer
    import itl_pkg::*;
#(
    parameter int PRESCALE_DIV = 6,
    parameter int CNT_W        = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   wr_idx,
    input  logic [7:0]   wr_data,
    input  logic [1:0]   acr_mode,
    input  logic [3:0]   rd_idx,
    output logic [7:0]   rd_data,
    output logic         tick_out,
    output logic [15:0]  t1_count,
    output logic [15:0]  t1_latch,
    output logic [15:0]  t2_count,
    output logic         t1_flag_set,
    output logic         t1_flag_clr,
    output logic         t2_flag_set
);
    localparam int BYTE_W = CNT_W / 2;

    logic tick;
    logic wr_t1_lo, wr_t1_load, wr_t1_lat_lo, wr_t1_lat_hi;
    logic wr_t2_lo, wr_t2_hi;
    logic free_run;

    assign wr_t1_lo     = wr_en && (wr_idx == IDX_T1_CNT_LO);
    assign wr_t1_load   = wr_en && (wr_idx == IDX_T1_CNT_HI);
    assign wr_t1_lat_lo = wr_en && (wr_idx == IDX_T1_LAT_LO);
    assign wr_t1_lat_hi = wr_en && (wr_idx == IDX_T1_LAT_HI);
    assign wr_t2_lo     = wr_en && (wr_idx == IDX_T2_LO);
    assign wr_t2_hi     = wr_en && (wr_idx == IDX_T2_HI);
    assign free_run     = (acr_mode == MODE_FREE_RUN);

    itl_prescale #(
        .DIV (PRESCALE_DIV)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    itl_timer1 #(
        .CNT_W (CNT_W)
    ) u_t1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .free_run_i  (free_run),
        .lat_lo_wr_i (wr_t1_lo | wr_t1_lat_lo),
        .lat_hi_wr_i (wr_t1_lat_hi),
        .load_wr_i   (wr_t1_load),
        .wdata_i     (wr_data[BYTE_W-1:0]),
        .count_o     (t1_count),
        .latch_o     (t1_latch),
        .flag_set_o  (t1_flag_set),
        .flag_clr_o  (t1_flag_clr)
    );

    itl_timer2 #(
        .CNT_W (CNT_W)
    ) u_t2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .lo_wr_i    (wr_t2_lo),
        .hi_wr_i    (wr_t2_hi),
        .wdata_i    (wr_data[BYTE_W-1:0]),
        .count_o    (t2_count),
        .flag_set_o (t2_flag_set)
    );

    assign tick_out = tick;

    // Readback mux
    always_comb begin
        unique case (rd_idx)
            IDX_T1_CNT_LO: rd_data = t1_count[BYTE_W-1:0];
            IDX_T1_CNT_HI: rd_data = t1_count[CNT_W-1:BYTE_W];
            IDX_T1_LAT_LO: rd_data = t1_latch[BYTE_W-1:0];
            IDX_T1_LAT_HI: rd_data = t1_latch[CNT_W-1:BYTE_W];
            IDX_T2_LO:     rd_data = t2_count[BYTE_W-1:0];
            IDX_T2_HI:     rd_data = t2_count[CNT_W-1:BYTE_W];
            default:       rd_data = '0;
        endcase
    end

    // R11: a load on a tick produces no flag-set pulse next cycle
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_t1_load && tick) |=> !t1_flag_set || (t1_count == '0))
        else $error("flag raised on load collision");

endmodule

// File: tb/dual_itimer_tb_top.sv
`timescale 1ns/1ps
module dual_itimer_tb_top;

    localparam int SEL_T1C = 0, SEL_T1L = 1, SEL_T2C = 2, SEL_RD = 3,
                   SEL_F1 = 4, SEL_F2 = 5, SEL_CLR = 6, SEL_CUST = 7;

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] exp;
        logic [15:0] act;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  acr_mode = 2'b00;
    logic [3:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        tick_out;
    logic [15:0] t1_count, t1_latch, t2_count;
    logic        t1_flag_set, t1_flag_clr, t2_flag_set;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    dual_itimer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .acr_mode(acr_mode), .rd_idx(rd_idx),
        .rd_data(rd_data), .tick_out(tick_out), .t1_count(t1_count),
        .t1_latch(t1_latch), .t2_count(t2_count), .t1_flag_set(t1_flag_set),
        .t1_flag_clr(t1_flag_clr), .t2_flag_set(t2_flag_set)
    );

    // Monitor: drains the scoreboard at every falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [15:0] got;
            it = sb_q.pop_front();
            case (it.sel)
                SEL_T1C: got = t1_count;
                SEL_T1L: got = t1_latch;
                SEL_T2C: got = t2_count;
                SEL_RD:  got = {8'h00, rd_data};
                SEL_F1:  got = {15'd0, t1_flag_set};
                SEL_F2:  got = {15'd0, t2_flag_set};
                SEL_CLR: got = {15'd0, t1_flag_clr};
                default: got = it.act;
            endcase
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
            end
        end
    end

    task automatic expect_val(input string req, input int sel, input logic [15:0] exp);
        sb_q.push_back('{req, sel, exp, 16'h0000});
    endtask

    task automatic expect_custom(input string req, input logic [15:0] exp, input logic [15:0] act);
        sb_q.push_back('{req, SEL_CUST, exp, act});
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [7:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Returns just after the clock edge that consumed a tick
    task automatic next_tick();
        do @(negedge clk); while (tick_out !== 1'b1);
        @(posedge clk); #1;
    endtask

    // Model of timer one from R6, one tick at a time
    task automatic t1_step(inout logic [15:0] v, inout bit under, input logic [15:0] lat);
        if (under) begin
            v = lat; under = 1'b0;
        end else if (v == 16'h0000) begin
            v = 16'hFFFF; under = 1'b1;
        end else begin
            v = v - 16'd1;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        logic [15:0] snap;
        logic [15:0] mv;
        bit          mu;
        int          gap;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_val("R1 t1 count", SEL_T1C, 16'hFFFF);
        expect_val("R1 t1 latch", SEL_T1L, 16'hFFFF);
        expect_val("R1 t2 count", SEL_T2C, 16'hFFFF);
        expect_val("R1 t1 flag", SEL_F1, 16'h0);
        expect_val("R1 t2 flag", SEL_F2, 16'h0);

        // R2 tick spacing
        do @(negedge clk); while (tick_out !== 1'b1);
        gap = 0;
        do begin @(negedge clk); gap++; end while (tick_out !== 1'b1);
        #1 expect_custom("R2 tick period", 16'd6, 16'(gap));

        // R8/R1: high write with reset low latch 0x00
        next_tick();
        do_write(4'd9, 8'h00);
        expect_val("R8 t2 load from reset latch (R1)", SEL_T2C, 16'h0000);
        next_tick();
        expect_val("R9 t2 wrap", SEL_T2C, 16'hFFFF);
        expect_val("R9 t2 first flag", SEL_F2, 16'h1);
        next_tick();
        expect_val("R9 t2 free decrement", SEL_T2C, 16'hFFFE);
        expect_val("R9 t2 no flag", SEL_F2, 16'h0);

        next_tick();
        snap = t2_count;
        do_write(4'd8, 8'h02);
        expect_val("R8 low write keeps count", SEL_T2C, snap);
        do_write(4'd9, 8'h00);
        expect_val("R8 t2 load", SEL_T2C, 16'h0002);
        rd_idx = 4'd8;
        expect_val("R10 rd t2 lo", SEL_RD, 16'h0002);
        for (int k = 0; k < 4; k++) begin
            logic [15:0] e2;
            next_tick();
            e2 = 16'h0002 - 16'(k + 1);
            expect_val("R9 t2 count", SEL_T2C, e2);
            expect_val("R9 t2 flag", SEL_F2, (k == 2) ? 16'h1 : 16'h0);
        end

        // R5 latch low writes
        acr_mode = 2'b01;
        next_tick();
        snap = t1_count;
        do_write(4'd6, 8'h34);
        expect_val("R5 latch lo via 6", SEL_T1L, 16'hFF34);
        expect_val("R5 count kept", SEL_T1C, snap);
        expect_val("R5 no clear", SEL_CLR, 16'h0);
        do_write(4'd4, 8'h05);
        expect_val("R5 latch lo via 4", SEL_T1L, 16'hFF05);
        expect_val("R5 count kept via 4", SEL_T1C, snap);

        // R3 loading write
        next_tick();
        do_write(4'd5, 8'h00);
        expect_val("R3 latch", SEL_T1L, 16'h0005);
        expect_val("R3 count", SEL_T1C, 16'h0005);
        expect_val("R3 clear pulse", SEL_CLR, 16'h1);

        // R6/R7 sequence in free-running mode
        mv = 16'h0005; mu = 1'b0;
        for (int k = 0; k < 14; k++) begin
            next_tick();
            t1_step(mv, mu, 16'h0005);
            expect_val("R6 t1 sequence", SEL_T1C, mv);
            expect_val("R7 t1 flag", SEL_F1, (mv == 16'h0) ? 16'h1 : 16'h0);
        end

        // R4 latch high write, then R10 readback
        next_tick();
        snap = t1_count;
        do_write(4'd7, 8'h01);
        expect_val("R4 count kept", SEL_T1C, snap);
        expect_val("R4 latch", SEL_T1L, 16'h0105);
        expect_val("R4 clear pulse", SEL_CLR, 16'h1);
        rd_idx = 4'd6;
        expect_val("R10 rd latch lo", SEL_RD, 16'h0005);
        @(posedge clk); #1 rd_idx = 4'd7;
        expect_val("R10 rd latch hi", SEL_RD, 16'h0001);
        @(posedge clk); #1 rd_idx = 4'd4;
        expect_val("R10 rd count lo", SEL_RD, {8'h00, snap[7:0]});
        @(posedge clk); #1 rd_idx = 4'd5;
        expect_val("R10 rd count hi", SEL_RD, {8'h00, snap[15:8]});
        rd_idx = 4'd0;

        // R7 zero latch: no flags in mode 00, flags in mode 01
        acr_mode = 2'b00;
        next_tick();
        do_write(4'd4, 8'h00);
        do_write(4'd5, 8'h00);
        expect_val("R3 zero load", SEL_T1C, 16'h0000);
        mv = 16'h0000; mu = 1'b0;
        for (int k = 0; k < 4; k++) begin
            next_tick();
            t1_step(mv, mu, 16'h0000);
            expect_val("R6 zero latch period", SEL_T1C, mv);
            expect_val("R7 gated off", SEL_F1, 16'h0);
        end
        acr_mode = 2'b01;
        for (int k = 0; k < 4; k++) begin
            next_tick();
            t1_step(mv, mu, 16'h0000);
            expect_val("R6 zero latch period", SEL_T1C, mv);
            expect_val("R7 zero reload flag", SEL_F1, (mv == 16'h0) ? 16'h1 : 16'h0);
        end

        // R11 load collides with a tick
        next_tick();
        do_write(4'd4, 8'h20);
        repeat (3) @(posedge clk);
        #1 wr_en = 1'b1; wr_idx = 4'd5; wr_data = 8'h00;
        if (tick_out !== 1'b1) expect_custom("R11 collision setup", 16'h1, 16'h0);
        @(posedge clk); #1 wr_en = 1'b0;
        expect_val("R11 load wins", SEL_T1C, 16'h0020);
        expect_val("R11 clear pulse", SEL_CLR, 16'h1);
        expect_val("R11 no set pulse", SEL_F1, 16'h0);
        next_tick();
        expect_val("R11 next tick decrements", SEL_T1C, 16'h001F);

        @(posedge clk); @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule